// File: doc/BRIEF.md
# PCI Configuration Address/Data Port

This block sits on the host side of a PCI bridge. It turns processor register accesses into PCI configuration read and write cycles. Software writes a target selector into the address-port register at offset 0x10C. It then reads or writes the data-port register at offset 0x110. Each data-port access launches a single configuration cycle toward a simplified initiator. While that cycle is in flight, the register bus is held off.

The selector register uses big-endian bit numbering, where bit 0 is the most significant bit. The block decodes four fields from it: register word, device, function and bus. It builds a type-0 or type-1 configuration address. For bus 0 it raises the IDSEL line that belongs to the device.

A cycle is launched only when three conditions hold: the selector's enable bit is set, the local function's bus-master enable is on, and its latency timer is non-zero. If any of these fails, the access completes at once with no bus activity. A read that finds no responder gets all-ones back.

Top module: `pci_cfg_port`

## Requirements
- R1: The address port stores the written word with bits (LSB numbering) [25:24] and [6:0] forced to zero. It reads back as `wdata & 32'hFCFFFF80`.
- R2: The fields use big-endian bit numbering, so bit k is LSB bit 31-k. The register word is in bits [31:26], the device in [23:19], the function in [18:16], the bus in [15:8], and the enable in [7]. With bus 0 the cycle is type 0: pciAddr = {16-bit IDSEL one-hot, 5'b0, function, register, 2'b00}. pciIdsel bit N is 1 for device N, so device N drives AD line 16+N. Devices 16 and above get no IDSEL.
- R3: With a non-zero bus the cycle is type 1: pciAddr = {8'h00, bus, device, function, register, 2'b01}, and pciIdsel is zero.
- R4: pciCmd is 4'b1010 for a configuration read and 4'b1011 for a configuration write. pciBeN (active low) is 4'b0000.
- R5: A data-port access with the enable bit clear launches no cycle. A read returns 32'hFFFFFFFF, and a write is dropped.
- R6: A data-port access while masterEnable is low, or while latencyTimer is zero, launches no cycle. A read returns 32'hFFFFFFFF.
- R7: A launched read returns pciRdata when pciDone completes it, and 32'hFFFFFFFF when pciTimeout ends it.
- R8: An accepted data access gives exactly one single-cycle pciStart pulse. cfgBusy is high from the cycle after acceptance until the cycle in which done or timeout is seen. regReady stays low throughout and pulses for one cycle afterwards.
- R9: For a write, pciWdata carries the data-port write value and holds it while the cycle is in flight.
- R10: An access to any other offset reads zero and leaves the address port unchanged.
- R11: After reset, cfgBusy, pciStart and regReady are low, and the address port reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regReq | input | 1 | Register access request, held until regReady |
| regWe | input | 1 | 1 = write, 0 = read |
| regOff | input | 12 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data, valid with regReady |
| regReady | output | 1 | One-cycle access completion |
| masterEnable | input | 1 | Local bus-master enable |
| latencyTimer | input | 8 | Local latency timer setting |
| cfgBusy | output | 1 | Configuration cycle in flight |
| pciStart | output | 1 | One-cycle cycle launch strobe |
| pciAddr | output | 32 | Configuration address phase value |
| pciCmd | output | 4 | Bus command code |
| pciBeN | output | 4 | Active-low byte enables |
| pciIdsel | output | 16 | One-hot IDSEL, bit N drives AD line 16+N |
| pciWdata | output | 32 | Write data for the cycle |
| pciRdata | input | 32 | Read data from the initiator |
| pciDone | input | 1 | Cycle completed |
| pciTimeout | input | 1 | Cycle ended without a responder |

## Verification
A wrong control state shows up at the ports within one clock. It appears as cfgBusy disagreeing with the launch and completion of the cycle, as a second pciStart, or as regReady arriving while a cycle is still open. A mis-decoded selector field first appears on pciAddr or pciIdsel in the cycle of the pciStart pulse. A wrong gating decision appears as a launch that should not happen, or as a read that returns something other than all-ones. The bench compares busy against a model on every clock, and it checks each launched cycle's address, command, IDSEL and data when the strobe occurs.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  typedef struct packed {
    logic loadAp;   // store address port
    logic launch;   // start a configuration cycle
    logic capBus;   // response from initiator data
    logic capOnes;  // response all-ones
    logic capAp;    // response address port value
    logic capZero;  // response zero
  } cfgStrb_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RESP} cfgState_t;

  localparam logic [3:0]  CMD_CFG_RD   = 4'b1010;
  localparam logic [3:0]  CMD_CFG_WR   = 4'b1011;
  localparam logic [31:0] AP_KEEP_MASK = 32'hFCFF_FF80;
endpackage

// File: rtl/cfg_port_dp.sv
module cfg_port_dp
  import pci_cfg_pkg::*;
#(
  parameter int IDSEL_BASE = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  cfgStrb_t                   strb,
  input  logic                       regWe,
  input  logic [31:0]                regWdata,
  input  logic [31:0]                pciRdata,
  output logic                       apEnable,
  output logic [31:0]                regRdata,
  output logic                       pciStart,
  output logic [31:0]                pciAddr,
  output logic [3:0]                 pciCmd,
  output logic [31-IDSEL_BASE:0]     pciIdsel,
  output logic [31:0]                pciWdata
);
  localparam int IDSEL_W = 32 - IDSEL_BASE;
  localparam int PAD_W   = IDSEL_BASE - 11;

  logic [31:0]        apQ;
  logic [5:0]         regNum;
  logic [4:0]         devNum;
  logic [2:0]         fnNum;
  logic [7:0]         busNum;
  logic [IDSEL_W-1:0] idselNext;
  logic [31:0]        addrNext;

  assign regNum   = apQ[31:26];
  assign devNum   = apQ[23:19];
  assign fnNum    = apQ[18:16];
  assign busNum   = apQ[15:8];
  assign apEnable = apQ[7];

  for (genvar i = 0; i < IDSEL_W; i++) begin : g_idsel
    assign idselNext[i] = (busNum == 8'd0) && (32'(devNum) == i);
  end

  always_comb begin
    if (busNum == 8'd0)
      addrNext = {idselNext, {PAD_W{1'b0}}, fnNum, regNum, 2'b00};
    else
      addrNext = {8'h00, busNum, devNum, fnNum, regNum, 2'b01};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      apQ      <= '0;
      regRdata <= '0;
      pciStart <= 1'b0;
      pciAddr  <= '0;
      pciCmd   <= '0;
      pciIdsel <= '0;
      pciWdata <= '0;
    end else begin
      pciStart <= strb.launch;
      if (strb.loadAp) apQ <= regWdata & AP_KEEP_MASK;
      if (strb.launch) begin
        pciAddr  <= addrNext;
        pciCmd   <= regWe ? CMD_CFG_WR : CMD_CFG_RD;
        pciIdsel <= idselNext;
        pciWdata <= regWdata;
      end
      if (strb.capBus)       regRdata <= pciRdata;
      else if (strb.capOnes) regRdata <= '1;
      else if (strb.capAp)   regRdata <= apQ;
      else if (strb.capZero) regRdata <= '0;
    end
  end

  p_start_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    pciStart |=> !pciStart);
  p_idsel_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pciIdsel));
  p_type0_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pciStart && pciIdsel != '0) |-> pciAddr[1:0] == 2'b00);
  p_wdata_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pciStart && !strb.launch) |=> $stable(pciWdata));
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import pci_cfg_pkg::*;
#(
  parameter int              OFF_W  = 12,
  parameter logic [OFF_W-1:0] AP_OFF = 12'h10C,
  parameter logic [OFF_W-1:0] DP_OFF = 12'h110
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regReq,
  input  logic             regWe,
  input  logic [OFF_W-1:0] regOff,
  input  logic             apEnable,
  input  logic             masterEnable,
  input  logic [7:0]       latencyTimer,
  input  logic             pciDone,
  input  logic             pciTimeout,
  output cfgStrb_t         strb,
  output logic             regReady,
  output logic             busy
);
  cfgState_t stateQ, stateD;
  logic gateOk;

  assign gateOk   = apEnable && masterEnable && (latencyTimer != 8'd0);
  assign regReady = (stateQ == ST_RESP);
  assign busy     = (stateQ == ST_WAIT);

  always_comb begin
    strb   = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (regReq) begin
        stateD = ST_RESP;
        if (regOff == AP_OFF) begin
          strb.loadAp = regWe;
          strb.capAp  = 1'b1;
        end else if (regOff == DP_OFF) begin
          if (gateOk) begin
            strb.launch = 1'b1;
            stateD      = ST_WAIT;
          end else begin
            strb.capOnes = 1'b1;
          end
        end else begin
          strb.capZero = 1'b1;
        end
      end
      ST_WAIT: if (pciDone) begin
        strb.capBus = 1'b1;
        stateD      = ST_RESP;
      end else if (pciTimeout) begin
        strb.capOnes = 1'b1;
        stateD       = ST_RESP;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    regReady |=> !regReady);
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !pciDone && !pciTimeout) |=> busy);
  p_ready_not_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    regReady |-> !busy);
endmodule

// File: rtl/pci_cfg_port.sv
module pci_cfg_port
  import pci_cfg_pkg::*;
#(
  parameter int              OFF_W      = 12,
  parameter logic [OFF_W-1:0] AP_OFF     = 12'h10C,
  parameter logic [OFF_W-1:0] DP_OFF     = 12'h110,
  parameter int              IDSEL_BASE = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regReq,
  input  logic                   regWe,
  input  logic [OFF_W-1:0]       regOff,
  input  logic [31:0]            regWdata,
  output logic [31:0]            regRdata,
  output logic                   regReady,
  input  logic                   masterEnable,
  input  logic [7:0]             latencyTimer,
  output logic                   cfgBusy,
  output logic                   pciStart,
  output logic [31:0]            pciAddr,
  output logic [3:0]             pciCmd,
  output logic [3:0]             pciBeN,
  output logic [31-IDSEL_BASE:0] pciIdsel,
  output logic [31:0]            pciWdata,
  input  logic [31:0]            pciRdata,
  input  logic                   pciDone,
  input  logic                   pciTimeout
);
  cfgStrb_t strb;
  logic     apEnable;

  assign pciBeN = 4'b0000;

  cfg_port_ctrl #(.OFF_W(OFF_W), .AP_OFF(AP_OFF), .DP_OFF(DP_OFF)) u_ctrl (
    .clk(clk), .rstN(rstN), .regReq(regReq), .regWe(regWe), .regOff(regOff),
    .apEnable(apEnable), .masterEnable(masterEnable), .latencyTimer(latencyTimer),
    .pciDone(pciDone), .pciTimeout(pciTimeout), .strb(strb),
    .regReady(regReady), .busy(cfgBusy)
  );

  cfg_port_dp #(.IDSEL_BASE(IDSEL_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWe(regWe), .regWdata(regWdata),
    .pciRdata(pciRdata), .apEnable(apEnable), .regRdata(regRdata),
    .pciStart(pciStart), .pciAddr(pciAddr), .pciCmd(pciCmd),
    .pciIdsel(pciIdsel), .pciWdata(pciWdata)
  );

  p_gate_master_r6: assert property (@(posedge clk) disable iff (!rstN)
    pciStart |-> ($past(masterEnable) && $past(latencyTimer) != 8'd0));
  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    pciStart |-> cfgBusy);
endmodule

// File: tb/pci_cfg_port_bench.sv
module pci_cfg_port_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regReq = 1'b0, regWe = 1'b0;
  logic [11:0] regOff = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic        regReady;
  logic        masterEnable = 1'b1;
  logic [7:0]  latencyTimer = 8'hFF;
  logic        cfgBusy, pciStart;
  logic [31:0] pciAddr, pciWdata;
  logic [3:0]  pciCmd, pciBeN;
  logic [15:0] pciIdsel;
  logic [31:0] pciRdata = '0;
  logic        pciDone = 1'b0, pciTimeout = 1'b0;

  int nChecks = 0, nFail = 0, startCnt = 0, cycles = 0;
  bit running = 1'b0;
  int rsLat = 2, rsMode = 0, phase = 0, cnt = 0;
  bit mBusy = 1'b0;
  logic [31:0] cAddr, cWdata;
  logic [3:0]  cCmd, cBe;
  logic [15:0] cIdsel;

  always #5 clk = ~clk;

  pci_cfg_port u_pci_cfg_port (
    .clk(clk), .rstN(rstN), .regReq(regReq), .regWe(regWe), .regOff(regOff),
    .regWdata(regWdata), .regRdata(regRdata), .regReady(regReady),
    .masterEnable(masterEnable), .latencyTimer(latencyTimer), .cfgBusy(cfgBusy),
    .pciStart(pciStart), .pciAddr(pciAddr), .pciCmd(pciCmd), .pciBeN(pciBeN),
    .pciIdsel(pciIdsel), .pciWdata(pciWdata), .pciRdata(pciRdata),
    .pciDone(pciDone), .pciTimeout(pciTimeout)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkSel(int rg, int dev, int fn, int bus, int en);
    return (32'(rg) << 26) | (32'(dev) << 19) | (32'(fn) << 16) | (32'(bus) << 8) | (32'(en) << 7);
  endfunction

  // initiator responder and per-clock busy model
  always @(negedge clk) begin
    if (running) begin
      pciDone = 1'b0; pciTimeout = 1'b0;
      if (phase == 2) begin mBusy = 1'b0; phase = 0; end
      if (pciStart) begin
        if (phase != 0) begin nChecks++; nFail++; $display("FAIL R8 second start actual=1 expected=0"); end
        startCnt++;
        mBusy = 1'b1; phase = 1; cnt = rsLat;
        cAddr = pciAddr; cCmd = pciCmd; cIdsel = pciIdsel; cWdata = pciWdata; cBe = pciBeN;
      end else if (phase == 1) begin
        if (pciWdata !== cWdata) begin nChecks++; nFail++; $display("FAIL R9 wdata moved actual=%h expected=%h", pciWdata, cWdata); end
        if (cnt == 0) begin
          if (rsMode == 0) pciDone = 1'b1; else pciTimeout = 1'b1;
          phase = 2;
        end else cnt--;
      end
      nChecks++;
      if (cfgBusy !== mBusy) begin
        nFail++;
        $display("FAIL R8 busy actual=%0b expected=%0b", cfgBusy, mBusy);
      end
      if (regReady && cfgBusy) begin nChecks++; nFail++; $display("FAIL R8 ready while busy actual=1 expected=0"); end
    end
  end

  task automatic access(input logic we, input logic [11:0] off, input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    regReq = 1'b1; regWe = we; regOff = off; regWdata = wd;
    @(negedge clk);
    while (!regReady) @(negedge clk);
    rd = regRdata;
    regReq = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        nChecks++; nFail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
      end
    end
  end

  initial begin
    logic [31:0] rd;
    int s0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 busy", 32'(cfgBusy), 0);
    chk("R11 start", 32'(pciStart), 0);
    chk("R11 ready", 32'(regReady), 0);
    running = 1'b1;
    access(0, 12'h10C, 0, rd); chk("R11 ap reset", rd, 0);

    // R1 masking
    access(1, 12'h10C, 32'hFFFF_FFFF, rd);
    access(0, 12'h10C, 0, rd); chk("R1 ap mask", rd, 32'hFCFF_FF80);
    access(1, 12'h10C, 32'h1234_5678, rd);
    access(0, 12'h10C, 0, rd); chk("R1 ap mask2", rd, 32'h1234_5678 & 32'hFCFF_FF80);

    // R10 other offset
    access(1, 12'h100, 32'hDEAD_BEEF, rd);
    access(0, 12'h100, 0, rd); chk("R10 other reads zero", rd, 0);
    access(0, 12'h10C, 0, rd); chk("R10 ap unchanged", rd, 32'h1234_5678 & 32'hFCFF_FF80);

    // R5 enable clear
    access(1, 12'h10C, mkSel(5, 8, 2, 0, 0), rd);
    s0 = startCnt;
    access(0, 12'h110, 0, rd); chk("R5 disabled read", rd, 32'hFFFF_FFFF);
    access(1, 12'h110, 32'h5555_AAAA, rd);
    chk("R5 no cycle", startCnt - s0, 0);

    // R6 latency zero, master off
    access(1, 12'h10C, mkSel(5, 8, 2, 0, 1), rd);
    latencyTimer = 8'h00; s0 = startCnt;
    access(0, 12'h110, 0, rd); chk("R6 lat zero read", rd, 32'hFFFF_FFFF);
    latencyTimer = 8'hFF; masterEnable = 1'b0;
    access(0, 12'h110, 0, rd); chk("R6 master off read", rd, 32'hFFFF_FFFF);
    chk("R6 no cycle", startCnt - s0, 0);
    masterEnable = 1'b1;

    // R2 type 0, device 8
    pciRdata = 32'h1234_5678; rsMode = 0; rsLat = 3; s0 = startCnt;
    access(0, 12'h110, 0, rd);
    chk("R8 one start", startCnt - s0, 1);
    chk("R7 read data", rd, 32'h1234_5678);
    chk("R2 type0 addr", cAddr, (32'h1 << 24) | (32'd2 << 8) | (32'd5 << 2));
    chk("R2 idsel dev8", 32'(cIdsel), 32'h0100);
    chk("R4 read cmd", 32'(cCmd), 32'hA);
    chk("R4 byte en", 32'(cBe), 0);

    // R2 devices 3 and 15
    access(1, 12'h10C, mkSel(0, 3, 0, 0, 1), rd);
    rsLat = 0; access(0, 12'h110, 0, rd);
    chk("R2 idsel dev3", 32'(cIdsel), 32'h0008);
    chk("R2 dev3 addr", cAddr, 32'h1 << 19);
    access(1, 12'h10C, mkSel(63, 15, 7, 0, 1), rd);
    access(0, 12'h110, 0, rd);
    chk("R2 idsel dev15", 32'(cIdsel), 32'h8000);
    chk("R2 dev15 addr", cAddr, (32'h1 << 31) | (32'd7 << 8) | (32'd63 << 2));

    // R3 type 1 write
    access(1, 12'h10C, mkSel(63, 7, 1, 5, 1), rd);
    rsLat = 4;
    access(1, 12'h110, 32'hCAFE_F00D, rd);
    chk("R3 type1 addr", cAddr, (32'd5 << 16) | (32'd7 << 11) | (32'd1 << 8) | (32'd63 << 2) | 32'd1);
    chk("R3 idsel zero", 32'(cIdsel), 0);
    chk("R4 write cmd", 32'(cCmd), 32'hB);
    chk("R9 write data", cWdata, 32'hCAFE_F00D);

    // R7 timeout
    rsMode = 1; rsLat = 2;
    access(0, 12'h110, 0, rd); chk("R7 timeout read", rd, 32'hFFFF_FFFF);
    rsMode = 0;

    repeat (4) @(negedge clk);
    running = 1'b0;
    finish_run();
  end
endmodule